// File: doc/BRIEF.md
# Jump and Call Target Resolver

This block works out where a control transfer lands on a processor with segmented 16-bit addressing. It takes one request at a time and resolves the target code segment and instruction offset for six transfer kinds. A far direct transfer takes both values from the instruction. A short relative transfer adds a signed 8-bit displacement and a near relative transfer adds a 16-bit displacement. A register transfer takes the offset straight from a register. The other two kinds read a stored 16-bit pointer from data memory: one at the offset held in a register, the other from a table entry chosen by an index.

Every resolved target appears on `new_cs`/`new_ip` together with a one-cycle `done` pulse. The forms that need no memory finish in the cycle after acceptance. The two memory-pointer forms perform two byte reads over a request/acknowledge port and take as many cycles as the memory needs. A memory-pointer form keeps the current code segment. Pushing return addresses and fetching opcodes are left to other units.

Top module: `flow_target_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `busy` and `mem_req` are low and `new_cs`/`new_ip` are 0x0000 until the first result.
- R2: Kind code 0 (far direct) produces `new_cs = imm_cs` and `new_ip = imm_ip`, with `done` high in the cycle after the request is accepted.
- R3: Kind code 1 (short relative) produces `new_ip = cur_ip + instr_len + sign-extended disp[7:0]` modulo 65536, ignores `disp[15:8]`, and keeps `new_cs = cur_cs`. `done` is high in the cycle after acceptance.
- R4: Kind code 2 (near relative) produces `new_ip = cur_ip + instr_len + disp` modulo 65536 and `new_cs = cur_cs`, with `done` high in the cycle after acceptance.
- R5: Kind code 3 (register) produces `new_ip = reg_val` and `new_cs = cur_cs`, with `done` high in the cycle after acceptance.
- R6: Kind code 4 (memory pointer) reads the low byte at data offset `reg_val` and then the high byte at offset `reg_val + 1` modulo 65536. The result is `new_ip = {high, low}`, with `new_cs` equal to `cur_cs` as it was at acceptance.
- R7: Kind code 5 (table) behaves as R6, except that the pointer offset is `reg_val + 2 * idx_val` modulo 65536.
- R8: Every memory address is `ds_val * 16 + offset` modulo 2^20, with `ds_val` taken at acceptance.
- R9: Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is seen at a clock edge. Each acknowledge transfers exactly one byte on `mem_rdata`, and any number of wait cycles is allowed.
- R10: Each accepted request gives exactly one `done` cycle. `new_cs`/`new_ip` change only in cycles where `done` is high.
- R11: `busy` is high from the cycle after a memory-pointer request is accepted until the cycle in which its `done` rises. A `req_valid` seen while `busy` is high is ignored.
- R12: Kind codes 6 and 7 are ignored: no `done`, no `mem_req`, and `new_cs`/`new_ip` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_kind | input | 3 | Transfer kind code (0..5 valid, 6..7 reserved) |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Offset of the transfer instruction |
| instr_len | input | 4 | Length in bytes of the transfer instruction |
| disp | input | 16 | Relative displacement (bits 7:0 for short form) |
| imm_cs | input | 16 | Segment carried by a far direct transfer |
| imm_ip | input | 16 | Offset carried by a far direct transfer |
| reg_val | input | 16 | Register operand: target, pointer offset or table base |
| idx_val | input | 16 | Table index |
| ds_val | input | 16 | Data segment used for pointer reads |
| busy | output | 1 | A memory-pointer resolution is in progress |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid on `mem_rdata` |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle result strobe |
| new_cs | output | 16 | Resolved code segment |
| new_ip | output | 16 | Resolved instruction offset |

## Verification
The hardest cases to reach from the ports are those where the second byte read crosses a boundary. One is a pointer at offset 0xFFFF, whose high byte must come from offset 0x0000 of the same segment. The other is a table entry whose linear address passes 2^20. The bench forces both by choosing register, index and segment values that place the pointer there. It returns byte values derived from each address, so a wrong address shows up as a wrong `new_ip`. A second difficult case is a request that arrives while a pointer read is stalled. The bench holds the memory responder in wait states and presents a register transfer in the middle of that window. It then counts `done` pulses and checks that the final offset still comes from memory.

// File: rtl/ftu_pkg.sv
package ftu_pkg;
  localparam int unsigned OFF_W     = 16;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned PA_W      = OFF_W + SEG_SHIFT;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LEN_W     = 4;
  localparam int unsigned KIND_W    = 3;

  typedef logic [OFF_W-1:0] off_t;
  typedef logic [PA_W-1:0]  pa_t;

  typedef enum logic [KIND_W-1:0] {
    K_FAR   = 3'd0,
    K_SHORT = 3'd1,
    K_NEAR  = 3'd2,
    K_REG   = 3'd3,
    K_MEM   = 3'd4,
    K_TABLE = 3'd5,
    K_RSV6  = 3'd6,
    K_RSV7  = 3'd7
  } xfer_kind_e;

  // Offset of the next instruction plus a displacement, wrapping in the segment.
  function automatic off_t rel_target(off_t ip, logic [LEN_W-1:0] len,
                                      off_t disp, logic is_short);
    off_t step;
    step = is_short ? {{(OFF_W-BYTE_W){disp[BYTE_W-1]}}, disp[BYTE_W-1:0]} : disp;
    return ip + off_t'(len) + step;
  endfunction

  // Segment shifted left plus offset, wrapping in the linear space.
  function automatic pa_t linear_addr(off_t seg, off_t off);
    return (pa_t'(seg) << SEG_SHIFT) + pa_t'(off);
  endfunction

  // Table entries are two bytes wide.
  function automatic off_t table_off(off_t base, off_t idx);
    return base + (idx << 1);
  endfunction
endpackage

// File: rtl/ftu_target_calc.sv
module ftu_target_calc
  import ftu_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  off_t              cur_cs,
  input  off_t              cur_ip,
  input  logic [LEN_W-1:0]  instr_len,
  input  off_t              disp,
  input  off_t              imm_cs,
  input  off_t              imm_ip,
  input  off_t              reg_val,
  input  off_t              idx_val,
  output off_t              tgt_cs,
  output off_t              tgt_ip,
  output off_t              ptr_off,
  output logic              is_mem,
  output logic              is_known
);
  xfer_kind_e k;
  assign k = xfer_kind_e'(kind);

  always_comb begin
    tgt_cs   = cur_cs;
    tgt_ip   = cur_ip;
    ptr_off  = reg_val;
    is_mem   = 1'b0;
    is_known = 1'b1;
    case (k)
      K_FAR: begin
        tgt_cs = imm_cs;
        tgt_ip = imm_ip;
      end
      K_SHORT: tgt_ip = rel_target(cur_ip, instr_len, disp, 1'b1);
      K_NEAR:  tgt_ip = rel_target(cur_ip, instr_len, disp, 1'b0);
      K_REG:   tgt_ip = reg_val;
      K_MEM:   is_mem = 1'b1;
      K_TABLE: begin
        is_mem  = 1'b1;
        ptr_off = table_off(reg_val, idx_val);
      end
      default: is_known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ftu_ptr_fetch.sv
module ftu_ptr_fetch
  import ftu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  off_t              seg,
  input  off_t              off,
  output logic              busy,
  output logic              mem_req,
  output pa_t               mem_addr,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              word_valid,
  output off_t              word
);
  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;

  fst_e              state;
  off_t              seg_q, off_q, cur_off;
  logic [BYTE_W-1:0] lo_q;

  assign cur_off  = (state == F_HI) ? off_q + off_t'(1) : off_q;
  assign mem_addr = linear_addr(seg_q, cur_off);
  assign mem_req  = (state != F_IDLE);
  assign busy     = (state != F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= F_IDLE;
      seg_q      <= '0;
      off_q      <= '0;
      lo_q       <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (state)
        F_IDLE: if (start) begin
          seg_q <= seg;
          off_q <= off;
          state <= F_LO;
        end
        F_LO: if (mem_ack) begin
          lo_q  <= mem_rdata;
          state <= F_HI;
        end
        F_HI: if (mem_ack) begin
          word       <= {mem_rdata, lo_q};
          word_valid <= 1'b1;
          state      <= F_IDLE;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  // R9: request and address held until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6: a word is only produced right after the high-byte acknowledge
  a_r6_word_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(state == F_HI && mem_ack));

  // R11: a new fetch never starts on top of a running one
  a_r11_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/flow_target_unit.sv
module flow_target_unit
  import ftu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [OFF_W-1:0]  cur_cs,
  input  logic [OFF_W-1:0]  cur_ip,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [OFF_W-1:0]  disp,
  input  logic [OFF_W-1:0]  imm_cs,
  input  logic [OFF_W-1:0]  imm_ip,
  input  logic [OFF_W-1:0]  reg_val,
  input  logic [OFF_W-1:0]  idx_val,
  input  logic [OFF_W-1:0]  ds_val,
  output logic              busy,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [OFF_W-1:0]  new_cs,
  output logic [OFF_W-1:0]  new_ip
);
  off_t tgt_cs, tgt_ip, ptr_off, fetch_word, cs_hold;
  logic is_mem, is_known, fetch_busy, word_valid;
  logic accept, simple_fire, mem_start;

  ftu_target_calc u_calc (
    .kind(req_kind), .cur_cs(cur_cs), .cur_ip(cur_ip), .instr_len(instr_len),
    .disp(disp), .imm_cs(imm_cs), .imm_ip(imm_ip), .reg_val(reg_val),
    .idx_val(idx_val), .tgt_cs(tgt_cs), .tgt_ip(tgt_ip), .ptr_off(ptr_off),
    .is_mem(is_mem), .is_known(is_known)
  );

  ftu_ptr_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .start(mem_start), .seg(ds_val), .off(ptr_off),
    .busy(fetch_busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .word_valid(word_valid), .word(fetch_word)
  );

  assign busy        = fetch_busy | word_valid;
  assign accept      = req_valid & ~busy & is_known;
  assign simple_fire = accept & ~is_mem;
  assign mem_start   = accept & is_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      new_cs  <= '0;
      new_ip  <= '0;
      cs_hold <= '0;
    end else begin
      done <= simple_fire | word_valid;
      if (mem_start) cs_hold <= cur_cs;
      if (simple_fire) begin
        new_cs <= tgt_cs;
        new_ip <= tgt_ip;
      end else if (word_valid) begin
        new_cs <= cs_hold;
        new_ip <= fetch_word;
      end
    end
  end

  // R10: results move only together with done
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_ip) && $stable(new_cs)));

  // R10: each done traces back to a simple acceptance or a finished fetch
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(simple_fire || word_valid));

  // R12: reserved kinds produce nothing
  a_r12_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !is_known) |=> (!done && !mem_req));

  // R11: busy spans exactly the fetch plus its hand-over cycle
  a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> busy);
endmodule

// File: tb/sim_flow_target_unit.sv
`timescale 1ns/1ps
module sim_flow_target_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] cur_cs, cur_ip, disp, imm_cs, imm_ip, reg_val, idx_val, ds_val;
  logic [3:0]  instr_len;
  logic        busy, mem_req, mem_ack, done;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] new_cs, new_ip;

  int n_chk = 0;
  int n_bad = 0;
  int lat   = 0;
  int wcnt  = 0;
  int n_log = 0;
  logic [19:0] addr_log [2];

  always #10 clk = ~clk;

  flow_target_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .instr_len(instr_len), .disp(disp),
    .imm_cs(imm_cs), .imm_ip(imm_ip), .reg_val(reg_val), .idx_val(idx_val),
    .ds_val(ds_val), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .new_cs(new_cs), .new_ip(new_ip)
  );

  function automatic logic [7:0] mem_pat(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic logic [19:0] lin(logic [15:0] s, logic [15:0] o);
    int v;
    v = (int'(s) * 16 + int'(o)) % (1 << 20);
    return v[19:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: byte data derived from the address, lat wait cycles
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt    = 0;
      end else if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ack   = 1'b1;
          mem_rdata = mem_pat(mem_addr);
          if (n_log < 2) addr_log[n_log] = mem_addr;
          n_log++;
        end else wcnt++;
      end
    end
  end

  task automatic drive(input logic [2:0] k, input logic [15:0] cs, ip,
                       input logic [3:0] len, input logic [15:0] d, ics, iip,
                       rv, ix, ds);
    req_kind = k; cur_cs = cs; cur_ip = ip; instr_len = len; disp = d;
    imm_cs = ics; imm_ip = iip; reg_val = rv; idx_val = ix; ds_val = ds;
    req_valid = 1'b1;
  endtask

  task automatic t_simple(input string rq, input logic [2:0] k,
                          input logic [15:0] cs, ip, input logic [3:0] len,
                          input logic [15:0] d, ics, iip, rv,
                          input logic [15:0] exp_cs, exp_ip);
    @(negedge clk);
    drive(k, cs, ip, len, d, ics, iip, rv, 16'h0, 16'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1, {rq, " done"}, {31'b0, done}, 1);
    chk(new_ip === exp_ip, {rq, " new_ip"}, new_ip, exp_ip);
    chk(new_cs === exp_cs, {rq, " new_cs"}, new_cs, exp_cs);
    @(negedge clk);
    chk(done === 1'b0, "R10 single done", {31'b0, done}, 0);
  endtask

  task automatic t_pointer(input string rq, input logic [2:0] k, input int l,
                           input logic [15:0] cs, rv, ix, ds, exp_off);
    int cyc;
    logic [19:0] a_lo, a_hi;
    logic [15:0] exp_ip;
    a_lo   = lin(ds, exp_off);
    a_hi   = lin(ds, exp_off + 16'd1);
    exp_ip = {mem_pat(a_hi), mem_pat(a_lo)};
    @(negedge clk);
    lat   = l;
    n_log = 0;
    drive(k, cs, 16'h0BAD, 4'd2, 16'h0, 16'h0, 16'h0, rv, ix, ds);
    @(negedge clk);
    req_valid = 1'b0;
    cur_cs    = 16'hEEEE;
    chk(busy === 1'b1, "R11 busy after accept", {31'b0, busy}, 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, {rq, " done seen"}, {31'b0, done}, 1);
    chk(busy === 1'b0, "R11 busy low at done", {31'b0, busy}, 0);
    chk(n_log == 2, "R9 two byte reads", n_log, 2);
    chk(addr_log[0] === a_lo, "R8 low byte address", addr_log[0], a_lo);
    chk(addr_log[1] === a_hi, "R8 high byte address", addr_log[1], a_hi);
    chk(new_ip === exp_ip, {rq, " new_ip"}, new_ip, exp_ip);
    chk(new_cs === cs, {rq, " new_cs"}, new_cs, cs);
    @(negedge clk);
    chk(done === 1'b0, "R10 single done", {31'b0, done}, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0;
    drive(3'd0, 16'h0, 16'h0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R1 reset strobes",
        {29'b0, done, busy, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(new_cs === 16'h0 && new_ip === 16'h0, "R1 reset outputs",
        {new_cs, new_ip}, 0);
    chk(done === 1'b0 && mem_req === 1'b0, "R1 idle after release",
        {30'b0, done, mem_req}, 0);
  endtask

  task automatic t_busy_ignore;
    int dones;
    logic [19:0] a_lo, a_hi;
    a_lo = lin(16'h0300, 16'h0040);
    a_hi = lin(16'h0300, 16'h0041);
    @(negedge clk);
    lat = 4; n_log = 0;
    drive(3'd4, 16'h7000, 16'h0, 4'd2, 16'h0, 16'h0, 16'h0, 16'h0040, 16'h0, 16'h0300);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1, "R11 busy while stalled", {31'b0, busy}, 1);
    drive(3'd3, 16'h1111, 16'h0, 4'd2, 16'h0, 16'h0, 16'h0, 16'hDEAD, 16'h0, 16'h0);
    @(negedge clk);
    req_valid = 1'b0;
    dones = 0;
    repeat (30) begin
      @(negedge clk);
      if (done === 1'b1) dones++;
    end
    chk(dones == 1, "R11 one done despite extra request", dones, 1);
    chk(new_ip === {mem_pat(a_hi), mem_pat(a_lo)}, "R11 result from memory",
        new_ip, {mem_pat(a_hi), mem_pat(a_lo)});
    chk(new_cs === 16'h7000, "R11 cs from accepted request", new_cs, 16'h7000);
  endtask

  task automatic t_reserved;
    logic [15:0] ocs, oip;
    bit quiet;
    @(negedge clk);
    ocs = new_cs; oip = new_ip;
    drive(3'd6, 16'h2222, 16'h3333, 4'd2, 16'h0, 16'h4444, 16'h5555, 16'h6666, 16'h0, 16'h0);
    @(negedge clk);
    req_kind = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    quiet = 1'b1;
    repeat (5) begin
      if (done !== 1'b0 || mem_req !== 1'b0) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R12 no done or read", {31'b0, quiet}, 1);
    chk(new_ip === oip, "R12 new_ip held", new_ip, oip);
    chk(new_cs === ocs, "R12 new_cs held", new_cs, ocs);
  endtask

  initial begin
    t_reset();
    t_simple("R2 far", 3'd0, 16'h1234, 16'h0100, 4'd5, 16'h0, 16'h1000, 16'h0000, 16'h0, 16'h1000, 16'h0000);
    t_simple("R2 far top", 3'd0, 16'h0001, 16'h0002, 4'd5, 16'h0, 16'hF000, 16'hFFF0, 16'h0, 16'hF000, 16'hFFF0);
    t_simple("R3 short fwd", 3'd1, 16'h0800, 16'h2000, 4'd2, 16'hAB7F, 16'h0, 16'h0, 16'h0, 16'h0800, 16'h2081);
    t_simple("R3 short back", 3'd1, 16'h0800, 16'h1000, 4'd2, 16'h00FE, 16'h0, 16'h0, 16'h0, 16'h0800, 16'h1000);
    t_simple("R3 short wrap", 3'd1, 16'h0900, 16'h0005, 4'd2, 16'h0080, 16'h0, 16'h0, 16'h0, 16'h0900, 16'hFF87);
    t_simple("R4 near wrap", 3'd2, 16'h0A00, 16'hFFF0, 4'd3, 16'h0020, 16'h0, 16'h0, 16'h0, 16'h0A00, 16'h0013);
    t_simple("R4 near back", 3'd2, 16'h0A00, 16'h1234, 4'd3, 16'hF000, 16'h0, 16'h0, 16'h0, 16'h0A00, 16'h0237);
    t_simple("R5 register", 3'd3, 16'h0B00, 16'h4000, 4'd2, 16'h0, 16'h0, 16'h0, 16'hBEEF, 16'h0B00, 16'hBEEF);
    t_pointer("R6 pointer", 3'd4, 0, 16'h2100, 16'h0100, 16'h0, 16'h0100, 16'h0100);
    t_pointer("R6 pointer stalled", 3'd4, 3, 16'h2200, 16'h0456, 16'h0, 16'h0200, 16'h0456);
    t_pointer("R6 pointer seg wrap", 3'd4, 1, 16'h2300, 16'hFFFF, 16'h0, 16'h1000, 16'hFFFF);
    t_pointer("R7 table", 3'd5, 2, 16'h2400, 16'h0200, 16'h0007, 16'h0400, 16'h020E);
    t_pointer("R7 table linear wrap", 3'd5, 0, 16'h2500, 16'h0010, 16'h0008, 16'hFFFF, 16'h0020);
    t_busy_ignore();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired before completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule